// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block picks which of four oscillator outputs drives the system clock and makes the change without glitches. Software writes a source code into a select field. A read-only status field reports the source that really drives the output at any moment. A change of select starts a switch only when the target's ready flag is high. The switch closes the old source's gate on that source's falling edge and waits until that has been seen. It then opens the new source's gate on the new source's falling edge, and only then updates status.

Hardware can override the select field in two cases: on exit from the low-power stop state, and when the external crystal fails while it is the status source. In both cases a wakeup bit picks the forced source: the fast internal RC or the low-power internal RC. While crystal monitoring is armed and the crystal is selected or in use, that bit cannot be written. A second bit records which RC the kernel clocks should use after stop. The block only stores that bit.

The control logic runs on a free-running configuration clock. Ready flags, events and write strobes are synchronous to that clock. Each source clock is resynchronised inside its own gate cell.

Top module: `sysclk_switch`

## Requirements
- R1: After reset the select field, status field, wakeup bit and kernel-wakeup bit are all 0, and the system clock follows source 0.
- R2: A select write with a code below 4 (0 fast internal RC, 1 low-power internal RC, 2 external crystal, 3 PLL) appears in the select field on the following configuration clock edge.
- R3: A select write with a code of 4 or more (reserved) leaves the select field unchanged.
- R4: Status takes only a value of 0 to 3 whose ready flag is high. While the target's ready flag is low, status keeps its old value and the old source keeps driving the system clock.
- R5: A stop-exit pulse sets select to 0 when the wakeup bit is 0, or to 1 when it is 1, on the next edge.
- R6: A crystal-failure pulse while status is 2 forces select to the source chosen by the wakeup bit. A pulse while status is not 2 has no effect.
- R7: A write to the wakeup bit is ignored while monitoring is enabled and either status or select equals 2. Otherwise it takes effect on the next edge.
- R8: The kernel-wakeup bit (0 fast RC, 1 low-power RC) follows its write strobe on the next edge, independently of the lock in R7.
- R9: Once status has settled, the system clock runs at the selected source's rate. No high or low phase of the system clock is shorter than the shortest half period among the sources.
- R10: A hardware force wins over a software select write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Free-running configuration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_clk | input | 4 | Source clocks, index = select code |
| src_rdy | input | 4 | Source ready flags, synchronous to cfg_clk |
| stop_exit | input | 1 | One-cycle pulse on leaving stop |
| xtal_fail | input | 1 | One-cycle crystal failure detect pulse |
| mon_en | input | 1 | Crystal monitoring armed |
| sel_wr | input | 1 | Select field write strobe |
| sel_wdata | input | 3 | Select write data |
| wake_wr | input | 1 | Wakeup bit write strobe |
| wake_wdata | input | 1 | Wakeup bit write data |
| kwake_wr | input | 1 | Kernel-wakeup bit write strobe |
| kwake_wdata | input | 1 | Kernel-wakeup bit write data |
| sys_clk | output | 1 | Glitch-free system clock |
| sel_q | output | 3 | Select field |
| stat_q | output | 3 | Status field |
| wake_q | output | 1 | Wakeup source bit |
| kwake_q | output | 1 | Kernel-wakeup source bit |

## Verification
The bench builds the block with its defaults: four sources, a 3-bit select field and two synchroniser stages. The 3-bit field leaves codes 4 to 7 free to exercise the reserved-write path. Every source gets its own period (16, 40, 24 and 10 ns). This makes a switch show up as a change in the counted edge rate, and the 5 ns half period sets the floor for runt pulses. Holding one ready flag low brings the blocked-switch case within reach. Stopping the crystal clock and pulsing the failure input covers the forced fallback from a dead source.

// File: rtl/sysclk_switch_pkg.sv
package sysclk_switch_pkg;
    // Handshake states of the switch sequencer
    typedef enum logic [1:0] {
        SW_IDLE  = 2'd0,
        SW_DROP  = 2'd1,
        SW_RAISE = 2'd2
    } sw_state_t;
endpackage

// File: rtl/sysclk_sel_regs.sv
// Select, wakeup and kernel-wakeup fields with the hardware override.
// Assumes all strobes and events are synchronous to clk and one cycle wide.
module sysclk_sel_regs #(
    parameter int N_SRC     = 4,
    parameter int SEL_W     = 3,
    parameter int HS_CODE   = 0,
    parameter int LP_CODE   = 1,
    parameter int XTAL_CODE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] stat,
    input  logic             stop_exit,
    input  logic             xtal_fail,
    input  logic             mon_en,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             wake_wr,
    input  logic             wake_wdata,
    input  logic             kwake_wr,
    input  logic             kwake_wdata,
    output logic [SEL_W-1:0] sel,
    output logic             wake,
    output logic             kwake
);
    localparam logic [SEL_W-1:0] XT = SEL_W'(XTAL_CODE);
    localparam logic [SEL_W-1:0] HS = SEL_W'(HS_CODE);
    localparam logic [SEL_W-1:0] LP = SEL_W'(LP_CODE);

    logic hw_force;
    logic wake_locked;
    logic code_ok;

    // Decode the override, the lock and the legality of a written code
    always_comb begin
        hw_force    = stop_exit || (xtal_fail && (stat == XT));
        wake_locked = mon_en && ((stat == XT) || (sel == XT));
        code_ok     = (sel_wdata < SEL_W'(N_SRC));
    end

    // Select field: a hardware force beats a software write
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= '0;
        else if (hw_force)
            sel <= wake ? LP : HS;
        else if (sel_wr && code_ok)
            sel <= sel_wdata;
    end

    // Wakeup bit, write-protected while the crystal is monitored and in play
    always_ff @(posedge clk) begin
        if (!rst_n)
            wake <= 1'b0;
        else if (wake_wr && !wake_locked)
            wake <= wake_wdata;
    end

    // Kernel-wakeup bit, plain storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            kwake <= 1'b0;
        else if (kwake_wr)
            kwake <= kwake_wdata;
    end
endmodule

// File: rtl/sysclk_switch_seq.sv
// Break-before-make sequencer: it turns requests off, waits for every live gate
// to report closed, then opens the target gate and updates status.
// Assumes src_rdy is synchronous to clk. A source whose ready flag is low
// counts as closed, so a dead clock cannot stall the fallback.
module sysclk_switch_seq
    import sysclk_switch_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int SEL_W = 3,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [N_SRC-1:0] src_rdy,
    input  logic [N_SRC-1:0] gate_on,
    output logic [N_SRC-1:0] req,
    output logic [SEL_W-1:0] stat
);
    localparam logic [N_SRC-1:0] RST_MASK = N_SRC'(1);

    logic [SYNC-1:0][N_SRC-1:0] ack_pipe;
    logic [N_SRC-1:0]           ack_s;
    logic [SEL_W-1:0]           tgt;
    sw_state_t                  state;
    logic                       sel_valid;
    logic                       sel_ready;
    logic                       tgt_on;

    assign ack_s = ack_pipe[SYNC-1];

    // Bring the gate states into the configuration domain
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_pipe <= {SYNC{RST_MASK}};
        else
            ack_pipe <= {ack_pipe[SYNC-2:0], gate_on};
    end

    // Readiness of the requested source and of the current target
    always_comb begin
        sel_valid = (sel < SEL_W'(N_SRC));
        sel_ready = 1'b0;
        tgt_on    = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel == SEL_W'(i)) sel_ready = src_rdy[i];
            if (tgt == SEL_W'(i)) tgt_on    = ack_s[i];
        end
    end

    // Switch sequence: close all gates, then open the target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SW_IDLE;
            req   <= RST_MASK;
            tgt   <= '0;
            stat  <= '0;
        end else begin
            case (state)
                SW_IDLE: begin
                    if ((sel != stat) && sel_valid && sel_ready) begin
                        tgt   <= sel;
                        req   <= '0;
                        state <= SW_DROP;
                    end
                end
                SW_DROP: begin
                    if ((ack_s & src_rdy) == '0) begin
                        req   <= RST_MASK << tgt;
                        state <= SW_RAISE;
                    end
                end
                SW_RAISE: begin
                    if (tgt_on) begin
                        stat  <= tgt;
                        state <= SW_IDLE;
                    end
                end
                default: state <= SW_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sysclk_gate_cell.sv
// One clock gate per source. The request is synchronised on rising edges and
// applied on a falling edge, so the gate only moves while the clock is low.
// Assumes the source runs during reset so that the reset takes hold.
module sysclk_gate_cell #(
    parameter int   SYNC   = 2,
    parameter logic RST_ON = 1'b0
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic req,
    output logic gate_on,
    output logic clk_out
);
    logic [SYNC-1:0] req_pipe;

    // Synchronise the request into this source's domain
    always_ff @(posedge src_clk) begin
        if (!rst_n)
            req_pipe <= {SYNC{RST_ON}};
        else
            req_pipe <= {req_pipe[SYNC-2:0], req};
    end

    // Move the gate only while the source clock is low
    always_ff @(negedge src_clk) begin
        if (!rst_n)
            gate_on <= RST_ON;
        else
            gate_on <= req_pipe[SYNC-1];
    end

    assign clk_out = src_clk & gate_on;
endmodule

// File: rtl/sysclk_switch.sv
// Top level: register fields, switch sequencer, and one gate per source
// combined by an OR. Assumes at most one gate is open on a running clock.
module sysclk_switch
    import sysclk_switch_pkg::*;
#(
    parameter int N_SRC     = 4,
    parameter int SEL_W     = 3,
    parameter int SYNC      = 2,
    parameter int HS_CODE   = 0,
    parameter int LP_CODE   = 1,
    parameter int XTAL_CODE = 2
) (
    input  logic             cfg_clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_clk,
    input  logic [N_SRC-1:0] src_rdy,
    input  logic             stop_exit,
    input  logic             xtal_fail,
    input  logic             mon_en,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             wake_wr,
    input  logic             wake_wdata,
    input  logic             kwake_wr,
    input  logic             kwake_wdata,
    output logic             sys_clk,
    output logic [SEL_W-1:0] sel_q,
    output logic [SEL_W-1:0] stat_q,
    output logic             wake_q,
    output logic             kwake_q
);
    logic [N_SRC-1:0] req_vec;
    logic [N_SRC-1:0] gate_on;
    logic [N_SRC-1:0] gated;

    sysclk_sel_regs #(
        .N_SRC(N_SRC), .SEL_W(SEL_W), .HS_CODE(HS_CODE),
        .LP_CODE(LP_CODE), .XTAL_CODE(XTAL_CODE)
    ) u_regs (
        .clk(cfg_clk), .rst_n(rst_n), .stat(stat_q),
        .stop_exit(stop_exit), .xtal_fail(xtal_fail), .mon_en(mon_en),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .wake_wr(wake_wr), .wake_wdata(wake_wdata),
        .kwake_wr(kwake_wr), .kwake_wdata(kwake_wdata),
        .sel(sel_q), .wake(wake_q), .kwake(kwake_q)
    );

    sysclk_switch_seq #(.N_SRC(N_SRC), .SEL_W(SEL_W), .SYNC(SYNC)) u_seq (
        .clk(cfg_clk), .rst_n(rst_n), .sel(sel_q), .src_rdy(src_rdy),
        .gate_on(gate_on), .req(req_vec), .stat(stat_q)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_gate
        sysclk_gate_cell #(.SYNC(SYNC), .RST_ON(g == 0)) u_cell (
            .src_clk(src_clk[g]), .rst_n(rst_n), .req(req_vec[g]),
            .gate_on(gate_on[g]), .clk_out(gated[g])
        );
    end

    assign sys_clk = |gated;
endmodule

// File: rtl/sysclk_switch_chk.sv
// Property checker for sysclk_switch, attached by bind.
module sysclk_switch_chk #(
    parameter int N_SRC     = 4,
    parameter int SEL_W     = 3,
    parameter int HS_CODE   = 0,
    parameter int LP_CODE   = 1,
    parameter int XTAL_CODE = 2
) (
    input logic             cfg_clk,
    input logic             rst_n,
    input logic             stop_exit,
    input logic             xtal_fail,
    input logic             mon_en,
    input logic             sel_wr,
    input logic [SEL_W-1:0] sel_wdata,
    input logic             wake_wr,
    input logic [SEL_W-1:0] sel_q,
    input logic [SEL_W-1:0] stat_q,
    input logic             wake_q,
    input logic             kwake_q,
    input logic [N_SRC-1:0] req_vec
);
    localparam logic [SEL_W-1:0] XT = SEL_W'(XTAL_CODE);
    localparam logic [SEL_W-1:0] HS = SEL_W'(HS_CODE);
    localparam logic [SEL_W-1:0] LP = SEL_W'(LP_CODE);

    p_reset_vals_r1: assert property (@(posedge cfg_clk)
        !rst_n |=> (sel_q == '0 && stat_q == '0 && !wake_q && !kwake_q));

    p_reserved_ignored_r3: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (sel_wr && sel_wdata >= SEL_W'(N_SRC) && !stop_exit && !(xtal_fail && stat_q == XT))
        |=> $stable(sel_q));

    p_stat_legal_r4: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        stat_q < SEL_W'(N_SRC));

    p_stop_force_r5: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        stop_exit |=> (sel_q == ($past(wake_q) ? LP : HS)));

    p_fail_force_r6: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (xtal_fail && stat_q == XT) |=> (sel_q == ($past(wake_q) ? LP : HS)));

    p_wake_lock_r7: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (wake_wr && mon_en && (stat_q == XT || sel_q == XT)) |=> $stable(wake_q));

    p_one_request_r9: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        $onehot0(req_vec));
endmodule

bind sysclk_switch sysclk_switch_chk #(
    .N_SRC(N_SRC), .SEL_W(SEL_W), .HS_CODE(HS_CODE),
    .LP_CODE(LP_CODE), .XTAL_CODE(XTAL_CODE)
) u_chk (
    .cfg_clk(cfg_clk), .rst_n(rst_n), .stop_exit(stop_exit),
    .xtal_fail(xtal_fail), .mon_en(mon_en), .sel_wr(sel_wr),
    .sel_wdata(sel_wdata), .wake_wr(wake_wr), .sel_q(sel_q),
    .stat_q(stat_q), .wake_q(wake_q), .kwake_q(kwake_q), .req_vec(req_vec)
);

// File: tb/tb_sysclk_switch.sv
`timescale 1ns/1ps
module tb_sysclk_switch;
    logic       cfg_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_clk = '0;
    logic [3:0] src_rdy = 4'hF;
    logic [3:0] run = 4'hF;
    logic       stop_exit = 0, xtal_fail = 0, mon_en = 0;
    logic       sel_wr = 0, wake_wr = 0, wake_wdata = 0, kwake_wr = 0, kwake_wdata = 0;
    logic [2:0] sel_wdata = '0;
    logic       sys_clk;
    logic [2:0] sel_q, stat_q;
    logic       wake_q, kwake_q;

    int checks = 0, failures = 0;
    int m_sel = 0, m_wake = 0, m_kwake = 0;
    logic [3:0] rdy_at_edge = 4'hF;
    int prev_stat = 0;
    int edge_cnt = 0;
    bit cnt_on = 0, armed = 0, model_on = 0;
    int runts = 0;
    realtime last_t = 0;

    sysclk_switch dut (
        .cfg_clk(cfg_clk), .rst_n(rst_n), .src_clk(src_clk), .src_rdy(src_rdy),
        .stop_exit(stop_exit), .xtal_fail(xtal_fail), .mon_en(mon_en),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata), .wake_wr(wake_wr),
        .wake_wdata(wake_wdata), .kwake_wr(kwake_wr), .kwake_wdata(kwake_wdata),
        .sys_clk(sys_clk), .sel_q(sel_q), .stat_q(stat_q),
        .wake_q(wake_q), .kwake_q(kwake_q)
    );

    always #10 cfg_clk = ~cfg_clk;
    always #8  src_clk[0] = run[0] ? ~src_clk[0] : 1'b0;
    always #20 src_clk[1] = run[1] ? ~src_clk[1] : 1'b0;
    always #12 src_clk[2] = run[2] ? ~src_clk[2] : 1'b0;
    always #5  src_clk[3] = run[3] ? ~src_clk[3] : 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model of the register fields, updated on each edge
    always @(posedge cfg_clk) begin
        int st;
        bit force_hw, lock;
        st = int'(stat_q);
        rdy_at_edge = src_rdy;
        if (!rst_n) begin
            m_sel = 0; m_wake = 0; m_kwake = 0;
        end else begin
            force_hw = stop_exit || (xtal_fail && st == 2);
            lock = mon_en && (st == 2 || m_sel == 2);
            if (force_hw) m_sel = m_wake;
            else if (sel_wr && sel_wdata < 4) m_sel = int'(sel_wdata);
            if (wake_wr && !lock) m_wake = int'(wake_wdata);
            if (kwake_wr) m_kwake = int'(kwake_wdata);
        end
    end

    // Compare against the model away from the edge
    always @(negedge cfg_clk) begin
        if (model_on) begin
            chk(int'(sel_q) == m_sel, "R2/R3/R5/R6/R10 sel", int'(sel_q), m_sel);
            chk(int'(wake_q) == m_wake, "R7 wake", int'(wake_q), m_wake);
            chk(int'(kwake_q) == m_kwake, "R8 kwake", int'(kwake_q), m_kwake);
            if (int'(stat_q) != prev_stat)
                chk(stat_q < 4 && rdy_at_edge[stat_q[1:0]], "R4 status source ready",
                    int'(stat_q), prev_stat);
        end
        prev_stat = int'(stat_q);
    end

    always @(posedge sys_clk) if (cnt_on) edge_cnt++;

    always @(sys_clk) begin
        if (armed && ($realtime - last_t) < 4.5) runts++;
        last_t = $realtime;
    end

    task automatic settle(input string req);
        int n = 0;
        @(negedge cfg_clk);
        while (stat_q != sel_q && n < 300) begin
            @(negedge cfg_clk);
            n++;
        end
        chk(stat_q == sel_q, req, int'(stat_q), int'(sel_q));
        repeat (4) @(negedge cfg_clk);
    endtask

    task automatic rate(input int expct, input string req);
        edge_cnt = 0;
        cnt_on = 1;
        repeat (40) @(negedge cfg_clk);
        cnt_on = 0;
        chk(edge_cnt >= expct - 2 && edge_cnt <= expct + 2, req, edge_cnt, expct);
    endtask

    task automatic wr_sel(input int v);
        @(negedge cfg_clk); sel_wr = 1; sel_wdata = 3'(v);
        @(negedge cfg_clk); sel_wr = 0;
    endtask

    task automatic wr_wake(input bit v);
        @(negedge cfg_clk); wake_wr = 1; wake_wdata = v;
        @(negedge cfg_clk); wake_wr = 0;
    endtask

    initial begin
        #150000;
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (6) @(negedge cfg_clk);
        rst_n = 1;
        // R1 reset state
        chk(sel_q == 0 && stat_q == 0, "R1 sel/stat reset", int'({sel_q, stat_q}), 0);
        chk(!wake_q && !kwake_q, "R1 wake bits reset", int'({wake_q, kwake_q}), 0);
        model_on = 1;
        repeat (6) @(negedge cfg_clk);
        armed = 1;
        rate(50, "R1 R9 rate source 0");
        // R2: move to the PLL
        wr_sel(3);
        chk(sel_q == 3, "R2 sel write", int'(sel_q), 3);
        settle("R4 settle on 3");
        rate(80, "R9 rate source 3");
        // R3: reserved code
        wr_sel(6);
        chk(sel_q == 3, "R3 reserved ignored", int'(sel_q), 3);
        // R4: target not ready
        @(negedge cfg_clk); src_rdy[1] = 0;
        wr_sel(1);
        repeat (30) @(negedge cfg_clk);
        chk(stat_q == 3, "R4 status held while not ready", int'(stat_q), 3);
        rate(80, "R4 old clock keeps running");
        @(negedge cfg_clk); src_rdy[1] = 1;
        settle("R4 settle on 1");
        rate(20, "R9 rate source 1");
        // R6: failure pulse with status not 2
        @(negedge cfg_clk); xtal_fail = 1;
        @(negedge cfg_clk); xtal_fail = 0;
        chk(sel_q == 1, "R6 failure ignored off crystal", int'(sel_q), 1);
        // R8
        @(negedge cfg_clk); kwake_wr = 1; kwake_wdata = 1;
        @(negedge cfg_clk); kwake_wr = 0;
        chk(kwake_q == 1, "R8 kernel wake write", int'(kwake_q), 1);
        // R5 + R10
        wr_wake(1);
        chk(wake_q == 1, "R7 wake write unlocked", int'(wake_q), 1);
        @(negedge cfg_clk); stop_exit = 1; sel_wr = 1; sel_wdata = 3;
        @(negedge cfg_clk); stop_exit = 0; sel_wr = 0;
        chk(sel_q == 1, "R5 R10 stop force to low-power RC", int'(sel_q), 1);
        wr_wake(0);
        @(negedge cfg_clk); stop_exit = 1;
        @(negedge cfg_clk); stop_exit = 0;
        chk(sel_q == 0, "R5 stop force to fast RC", int'(sel_q), 0);
        settle("R4 settle on 0");
        // R7 lock
        wr_sel(2);
        @(negedge cfg_clk); mon_en = 1;
        wr_wake(1);
        chk(wake_q == 0, "R7 wake locked (sel 2)", int'(wake_q), 0);
        settle("R4 settle on 2");
        rate(33, "R9 rate source 2");
        wr_wake(1);
        chk(wake_q == 0, "R7 wake locked (status 2)", int'(wake_q), 0);
        // R6 crystal failure while in use
        @(negedge cfg_clk); run[2] = 0; src_rdy[2] = 0;
        repeat (3) @(negedge cfg_clk);
        xtal_fail = 1;
        @(negedge cfg_clk); xtal_fail = 0;
        chk(sel_q == 0, "R6 failure forces fast RC", int'(sel_q), 0);
        settle("R6 fallback settles");
        rate(50, "R6 R9 rate after fallback");
        wr_wake(1);
        chk(wake_q == 1, "R7 unlocked once crystal unused", int'(wake_q), 1);
        chk(runts == 0, "R9 no runt phases", runts, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule